// File: doc/BRIEF.md
# Flash Programming Address Pointer and Row Latch Buffer

This block sits behind a serial programming command decoder and owns the word address used during programming. It also owns a bank of 32 word latches that gather data ahead of a commit. The decoder hands it one command strobe at a time. The block moves the address, fills the latches, and turns commit and erase commands into one-cycle request pulses for the flash array model. It withholds a request whenever the address region or the code-protection input forbids that request.

The address has two regions: a program region below 2000h and a configuration region from 2000h upward. Incrementing the address wraps inside the current region and never crosses into the other one. A commit writes a whole aligned row of 32 words. The row is chosen by the address at the moment of the commit. Latch i supplies the word at offset i within that row.

Each accepted request is followed by a busy window of a parameterised length. The window stands in for the programming or erase time. Commands that arrive during the window are dropped.

Top module: `prog_addr_latch`

## Requirements
- R1: After reset, addr_o is 0000h, busy_o is low, no request pulse is high, and every latch holds 3FFFh.
- R2: The command codes on cmd_i are: 0 load-config, 1 load-data, 2 increment, 3 reset-address, 4 commit, 5 row-erase, 6 bulk-erase. Code 7 is ignored. Load-config sets the address to 2000h and writes data_i into latch 0. Load-data writes data_i into the latch indexed by addr_o[4:0].
- R3: Reset-address sets addr_o to 0000h from any value.
- R4: Increment adds one to addr_o[12:0] and keeps bit 13. So 1FFFh goes to 0000h and 3FFFh goes to 2000h.
- R5: A later load to the same latch index overwrites the earlier contents. This includes a load 32 words further on.
- R6: An accepted commit raises wr_req_o for one cycle, in the cycle after the command. In that cycle, row_o holds addr_o[13:5] from the time of the command, and wr_data_o bits [14i+13:14i] hold latch i. After the pulse, all latches return to 3FFFh.
- R7: A commit is ignored in two cases. The first is cp_on_i high with an address below 2000h. The second is ext_timed_i high with the address at 2007h or 2008h.
- R8: Row-erase behaves by address range. Below 2000h with cp_on_i low, it pulses row_erase_o with uid_sel_o low. From 2000h to 2008h, it pulses row_erase_o with uid_sel_o high, whatever cp_on_i is. Otherwise it is ignored.
- R9: Bulk-erase behaves by address range. Below 2000h, it pulses bulk_erase_o with uid_sel_o low. From 2000h to 2008h, it pulses bulk_erase_o with uid_sel_o high. Above 2008h it is ignored. cp_on_i has no effect on it.
- R10: busy_o rises together with each request pulse and stays high for BUSY_CYCLES cycles. Every command received while busy_o is high is ignored.
- R11: At most one request pulse is high at a time. An ignored commit or erase raises neither a pulse nor busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | Command code |
| data_i | input | 14 | Word for load-data and load-config |
| cp_on_i | input | 1 | Code protection active |
| ext_timed_i | input | 1 | Commit is externally timed |
| addr_o | output | 14 | Current word address |
| busy_o | output | 1 | Operation in progress |
| wr_req_o | output | 1 | Row write request pulse |
| row_erase_o | output | 1 | Row erase request pulse |
| bulk_erase_o | output | 1 | Bulk erase request pulse |
| uid_sel_o | output | 1 | Erase request includes, or is limited to, the user ID words |
| row_o | output | 9 | Row number addressed by the request |
| wr_data_o | output | 448 | All latches, latch i at bits [14i+13:14i] |

## Verification
The bench builds the block with the default 14-bit address and 32-word rows, and sets BUSY_CYCLES to 4. With a short busy window, the bench can measure the exact busy length and still test command rejection without long waits. With the full address width, it can walk the address all the way to both wrap points, 1FFFh and 3FFFh. It can also place the pointer at the region edges 2007h, 2008h and 2009h, where the protection and range rules change.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [2:0] {
    CMD_LOAD_CFG   = 3'd0,
    CMD_LOAD_DATA  = 3'd1,
    CMD_INC        = 3'd2,
    CMD_RST_ADDR   = 3'd3,
    CMD_COMMIT     = 3'd4,
    CMD_ROW_ERASE  = 3'd5,
    CMD_BULK_ERASE = 3'd6,
    CMD_NONE       = 3'd7
  } cmd_e;
endpackage

// File: rtl/pal_addr_ctr.sv
module pal_addr_ctr #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_cfg_i,
  input  logic              rst_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_o <= '0;
    else if (rst_addr_i) addr_o <= '0;
    else if (ld_cfg_i)   addr_o <= CFG_BASE;
    // region bit held, low part wraps
    else if (inc_i)      addr_o <= {addr_o[ADDR_W-1], addr_o[ADDR_W-2:0] + 1'b1};
  end
endmodule

// File: rtl/pal_latch_buf.sv
module pal_latch_buf #(
  parameter int WORD_W   = 14,
  parameter int ROW_BITS = 5,
  localparam int NUM     = 1 << ROW_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ROW_BITS-1:0]   idx_i,
  input  logic [WORD_W-1:0]     data_i,
  input  logic                  clr_i,
  output logic [NUM*WORD_W-1:0] data_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_lat
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '1;
      else if (clr_i)                               word_q <= '1;
      else if (we_i && idx_i == ROW_BITS'(i))       word_q <= data_i;
    end
    assign data_o[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/pal_req_gen.sv
module pal_req_gen #(
  parameter int                 ADDR_W      = 14,
  parameter int                 ROW_BITS    = 5,
  parameter logic [ADDR_W-1:0]  CFG_WORD_LO = 14'h2007,
  parameter logic [ADDR_W-1:0]  CFG_END     = 14'h2008,
  localparam int                ROW_W       = ADDR_W - ROW_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              row_erase_i,
  input  logic              bulk_erase_i,
  input  logic              cp_on_i,
  input  logic              ext_timed_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              go_o,
  output logic              wr_req_o,
  output logic              row_erase_o,
  output logic              bulk_erase_o,
  output logic              uid_sel_o,
  output logic [ROW_W-1:0]  row_o
);
  logic in_prog, in_uid, cfg_word, wr_ok, re_ok, be_ok;

  always_comb begin
    in_prog  = !addr_i[ADDR_W-1];
    in_uid   = addr_i[ADDR_W-1] && (addr_i <= CFG_END);
    cfg_word = (addr_i == CFG_WORD_LO) || (addr_i == CFG_WORD_LO + 1'b1);
    wr_ok    = commit_i && !(in_prog && cp_on_i) && !(ext_timed_i && cfg_word);
    re_ok    = row_erase_i && ((in_prog && !cp_on_i) || in_uid);
    be_ok    = bulk_erase_i && (in_prog || in_uid);
    go_o     = wr_ok || re_ok || be_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_req_o     <= 1'b0;
      row_erase_o  <= 1'b0;
      bulk_erase_o <= 1'b0;
      uid_sel_o    <= 1'b0;
      row_o        <= '0;
    end else begin
      wr_req_o     <= wr_ok;
      row_erase_o  <= re_ok;
      bulk_erase_o <= be_ok;
      uid_sel_o    <= (re_ok || be_ok) && in_uid;
      row_o        <= addr_i[ADDR_W-1:ROW_BITS];
    end
  end
endmodule

// File: rtl/pal_busy_timer.sv
module pal_busy_timer #(
  parameter int  BUSY_CYCLES = 16,
  localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/prog_addr_latch.sv
module prog_addr_latch #(
  parameter int                ADDR_W      = 14,
  parameter int                WORD_W      = 14,
  parameter int                ROW_BITS    = 5,
  parameter int                BUSY_CYCLES = 16,
  parameter logic [ADDR_W-1:0] CFG_WORD_LO = 14'h2007,
  parameter logic [ADDR_W-1:0] CFG_END     = 14'h2008,
  localparam int               NUM         = 1 << ROW_BITS,
  localparam int               ROW_W       = ADDR_W - ROW_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [2:0]            cmd_i,
  input  logic [WORD_W-1:0]     data_i,
  input  logic                  cp_on_i,
  input  logic                  ext_timed_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  busy_o,
  output logic                  wr_req_o,
  output logic                  row_erase_o,
  output logic                  bulk_erase_o,
  output logic                  uid_sel_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [NUM*WORD_W-1:0] wr_data_o
);
  import pal_pkg::*;

  logic                acc, go;
  logic                s_ld_cfg, s_ld_data, s_inc, s_rst, s_commit, s_rerase, s_berase;
  logic [ROW_BITS-1:0] lat_idx;

  always_comb begin
    acc       = cmd_valid_i && !busy_o;
    s_ld_cfg  = acc && (cmd_e'(cmd_i) == CMD_LOAD_CFG);
    s_ld_data = acc && (cmd_e'(cmd_i) == CMD_LOAD_DATA);
    s_inc     = acc && (cmd_e'(cmd_i) == CMD_INC);
    s_rst     = acc && (cmd_e'(cmd_i) == CMD_RST_ADDR);
    s_commit  = acc && (cmd_e'(cmd_i) == CMD_COMMIT);
    s_rerase  = acc && (cmd_e'(cmd_i) == CMD_ROW_ERASE);
    s_berase  = acc && (cmd_e'(cmd_i) == CMD_BULK_ERASE);
    // load-config targets the first word of the config row
    lat_idx   = s_ld_cfg ? '0 : addr_o[ROW_BITS-1:0];
  end

  pal_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .ld_cfg_i   (s_ld_cfg),
    .rst_addr_i (s_rst),
    .inc_i      (s_inc),
    .addr_o     (addr_o)
  );

  pal_latch_buf #(.WORD_W(WORD_W), .ROW_BITS(ROW_BITS)) u_lat (
    .clk_i, .rst_ni,
    .we_i   (s_ld_cfg || s_ld_data),
    .idx_i  (lat_idx),
    .data_i (data_i),
    .clr_i  (wr_req_o),
    .data_o (wr_data_o)
  );

  pal_req_gen #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS),
    .CFG_WORD_LO(CFG_WORD_LO), .CFG_END(CFG_END)
  ) u_req (
    .clk_i, .rst_ni,
    .commit_i     (s_commit),
    .row_erase_i  (s_rerase),
    .bulk_erase_i (s_berase),
    .cp_on_i      (cp_on_i),
    .ext_timed_i  (ext_timed_i),
    .addr_i       (addr_o),
    .go_o         (go),
    .wr_req_o     (wr_req_o),
    .row_erase_o  (row_erase_o),
    .bulk_erase_o (bulk_erase_o),
    .uid_sel_o    (uid_sel_o),
    .row_o        (row_o)
  );

  pal_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni,
    .start_i (go),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/prog_addr_latch_chk.sv
module prog_addr_latch_chk #(
  parameter int                ADDR_W      = 14,
  parameter int                ROW_BITS    = 5,
  parameter logic [ADDR_W-1:0] CFG_WORD_LO = 14'h2007,
  parameter logic [ADDR_W-1:0] CFG_END     = 14'h2008
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cmd_valid_i,
  input logic [2:0]                 cmd_i,
  input logic                       cp_on_i,
  input logic                       ext_timed_i,
  input logic [ADDR_W-1:0]          addr_o,
  input logic                       busy_o,
  input logic                       wr_req_o,
  input logic                       row_erase_o,
  input logic                       bulk_erase_o,
  input logic                       uid_sel_o,
  input logic [ADDR_W-ROW_BITS-1:0] row_o
);
  import pal_pkg::*;
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W-1);

  AST_INC_KEEPS_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_i == 3'(CMD_INC)) |=> addr_o[ADDR_W-1] == $past(addr_o[ADDR_W-1])); // R4
  AST_RST_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_i == 3'(CMD_RST_ADDR)) |=> addr_o == '0); // R3
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_req_o, row_erase_o, bulk_erase_o}) <= 1); // R11
  AST_REQ_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o || row_erase_o || bulk_erase_o) |-> busy_o && !$past(busy_o)); // R10
  AST_WR_ROW_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> row_o == $past(addr_o[ADDR_W-1:ROW_BITS])); // R6
  AST_WR_PROTECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !($past(cp_on_i) && !$past(addr_o[ADDR_W-1]))); // R7
  AST_WR_EXT_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !($past(ext_timed_i) &&
                   ($past(addr_o) == CFG_WORD_LO || $past(addr_o) == CFG_WORD_LO + 1'b1))); // R7
  AST_ROW_ERASE_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_erase_o && !uid_sel_o) |-> !$past(cp_on_i) && !$past(addr_o[ADDR_W-1])); // R8
  AST_BULK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_erase_o |-> $past(addr_o) <= CFG_END); // R9
  AST_UID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uid_sel_o |-> $past(addr_o) >= CFG_BASE && $past(addr_o) <= CFG_END); // R8
endmodule

bind prog_addr_latch prog_addr_latch_chk #(
  .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .CFG_WORD_LO(CFG_WORD_LO), .CFG_END(CFG_END)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .cp_on_i(cp_on_i), .ext_timed_i(ext_timed_i), .addr_o(addr_o), .busy_o(busy_o),
  .wr_req_o(wr_req_o), .row_erase_o(row_erase_o), .bulk_erase_o(bulk_erase_o),
  .uid_sel_o(uid_sel_o), .row_o(row_o)
);

// File: tb/prog_addr_latch_bench.sv
`timescale 1ns/1ps
module prog_addr_latch_bench;
  localparam int BUSY = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd = 3'd7;
  logic [13:0]  data = '0;
  logic         cp_on = 1'b0;
  logic         ext = 1'b0;
  logic [13:0]  addr;
  logic         busy, wr_req, row_er, bulk_er, uid_sel;
  logic [8:0]   row;
  logic [447:0] wdata;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  prog_addr_latch #(.BUSY_CYCLES(BUSY)) u_prog_addr_latch (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .data_i(data),
    .cp_on_i(cp_on), .ext_timed_i(ext), .addr_o(addr), .busy_o(busy),
    .wr_req_o(wr_req), .row_erase_o(row_er), .bulk_erase_o(bulk_er),
    .uid_sel_o(uid_sel), .row_o(row), .wr_data_o(wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [13:0] d);
    cmd_valid = 1'b1; cmd = c; data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd7;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic go_to(input int a);
    issue(3'd3, 0);
    for (int i = 0; i < a; i++) issue(3'd2, 0);
  endtask

  task automatic check_quiet(input string tag);
    check({tag, " no pulse"}, {29'd0, wr_req, row_er, bulk_er}, 0);
    check({tag, " not busy"}, busy, 0);
  endtask

  task automatic t_reset();
    check("R1 addr", addr, 14'h0000);
    check_quiet("R1");
    issue(3'd4, 0);
    check("R1 commit pulse", wr_req, 1);
    for (int i = 0; i < 32; i++) check("R1 latch blank", wdata[i*14 +: 14], 14'h3FFF);
    wait_idle();
  endtask

  task automatic t_load_commit();
    go_to(14'h45);
    issue(3'd1, 14'h1234);
    issue(3'd2, 0);
    issue(3'd1, 14'h2ABC);
    issue(3'd7, 14'h0777);
    check("R2 code 7 ignored addr", addr, 14'h0046);
    check_quiet("R2 code 7");
    issue(3'd4, 0);
    check("R6 pulse", wr_req, 1);
    check("R6 row", row, 9'd2);
    check("R6 slot5", wdata[5*14 +: 14], 14'h1234);
    check("R6 slot6", wdata[6*14 +: 14], 14'h2ABC);
    check("R6 slot7 blank", wdata[7*14 +: 14], 14'h3FFF);
    check("R2 code 7 no latch write", wdata[0 +: 14], 14'h3FFF);
    @(negedge clk);
    check("R6 single cycle", wr_req, 0);
    wait_idle();
    issue(3'd4, 0);
    check("R6 cleared slot5", wdata[5*14 +: 14], 14'h3FFF);
    check("R6 cleared slot6", wdata[6*14 +: 14], 14'h3FFF);
    wait_idle();
  endtask

  task automatic t_overwrite();
    go_to(0);
    issue(3'd1, 14'h0AAA);
    issue(3'd1, 14'h0BBB);
    for (int i = 0; i < 32; i++) issue(3'd2, 0);
    issue(3'd1, 14'h1CCC);
    issue(3'd4, 0);
    check("R5 row", row, 9'd1);
    check("R5 overwrite slot0", wdata[0 +: 14], 14'h1CCC);
    wait_idle();
  endtask

  task automatic t_wrap();
    go_to(14'h1FFF);
    check("R4 reach 1FFF", addr, 14'h1FFF);
    issue(3'd2, 0);
    check("R4 wrap prog", addr, 14'h0000);
    issue(3'd0, 14'h0ABC);
    check("R2 load cfg addr", addr, 14'h2000);
    issue(3'd4, 0);
    check("R2 cfg commit row", row, 9'h100);
    check("R2 cfg latch0", wdata[0 +: 14], 14'h0ABC);
    wait_idle();
    for (int i = 0; i < 14'h1FFF; i++) issue(3'd2, 0);
    check("R4 reach 3FFF", addr, 14'h3FFF);
    issue(3'd2, 0);
    check("R4 wrap cfg", addr, 14'h2000);
    go_to(14'h123);
    issue(3'd3, 0);
    check("R3 reset addr", addr, 14'h0000);
  endtask

  task automatic t_protect();
    go_to(14'h45);
    cp_on = 1'b1;
    issue(3'd4, 0);
    check_quiet("R7 cp commit");
    cp_on = 1'b0;
    issue(3'd0, 14'h0001);
    for (int i = 0; i < 7; i++) issue(3'd2, 0);
    check("R7 at 2007", addr, 14'h2007);
    ext = 1'b1;
    issue(3'd4, 0);
    check_quiet("R7 ext cfg word");
    ext = 1'b0;
    issue(3'd4, 0);
    check("R7 internal cfg ok", wr_req, 1);
    wait_idle();
  endtask

  task automatic t_row_erase();
    go_to(14'h45);
    issue(3'd5, 0);
    check("R8 prog pulse", row_er, 1);
    check("R8 prog uid", uid_sel, 0);
    check("R8 prog row", row, 9'd2);
    check("R11 only one", {wr_req, bulk_er}, 0);
    wait_idle();
    cp_on = 1'b1;
    issue(3'd5, 0);
    check_quiet("R8 cp prog");
    issue(3'd0, 0);
    for (int i = 0; i < 3; i++) issue(3'd2, 0);
    issue(3'd5, 0);
    check("R8 uid pulse cp", row_er, 1);
    check("R8 uid sel", uid_sel, 1);
    wait_idle();
    for (int i = 0; i < 6; i++) issue(3'd2, 0);
    check("R8 at 2009", addr, 14'h2009);
    cp_on = 1'b0;
    issue(3'd5, 0);
    check_quiet("R8 above uid");
  endtask

  task automatic t_bulk();
    cp_on = 1'b1;
    go_to(14'h45);
    issue(3'd6, 0);
    check("R9 prog bulk cp", bulk_er, 1);
    check("R9 prog uid", uid_sel, 0);
    wait_idle();
    issue(3'd0, 0);
    for (int i = 0; i < 8; i++) issue(3'd2, 0);
    issue(3'd6, 0);
    check("R9 2008 bulk", bulk_er, 1);
    check("R9 2008 uid", uid_sel, 1);
    wait_idle();
    issue(3'd2, 0);
    issue(3'd6, 0);
    check_quiet("R9 2009");
    cp_on = 1'b0;
  endtask

  task automatic t_busy();
    int n = 0;
    go_to(14'h10);
    issue(3'd4, 0);
    issue(3'd2, 0);
    while (busy) begin n++; @(negedge clk); end
    check("R10 busy length", n + 1, BUSY);
    check("R10 cmd ignored while busy", addr, 14'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_commit();
    t_overwrite();
    t_wrap();
    t_protect();
    t_row_erase();
    t_bulk();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule